// File: doc/BRIEF.md
# Two-Channel PIO Access and Activity Latch Unit

This block sits behind the byte layer of a single-wire slave and owns a small group of open-drain general-purpose pins. After the command layer has addressed the slave, each received byte arrives on `rx_byte` with `rx_valid`. Each byte the master wants to read is requested with a one-cycle `tx_req`, and the answer appears on `tx_byte` with `tx_valid` exactly one cycle later. A synchronous `bus_rst` ends whatever command is running. The output latch, the activity latches and the search configuration all survive it.

Six commands are decoded in the idle state. Stream read (F5h) returns the pin status in an endless loop and places an inverted CRC-16 after every block of status bytes. Pin write (5Ah) takes data/complement pairs, answers AAh, then returns a fresh pin sample. Pulse (A5h) pulls the masked pins low for a fixed number of cycles. Clear activity (C3h) clears the change latches. Configure (3Ch) loads the search select mask, the polarity mask and the combine mode. Register read (69h) returns the activity latches and the three configuration values. A two-flop synchronised copy of the pins feeds sticky activity latches. Those latches are compared with the polarity mask to form `cond_out`, which the search layer uses to decide whether the slave takes part in a conditional search.

States: `ST_IDLE`, `ST_RD_STREAM`, `ST_WR_DATA`, `ST_WR_INV`, `ST_WR_ACK`, `ST_WR_SAMPLE`, `ST_PULSE_MASK`, `ST_PULSE_RUN`, `ST_CFG_SEL`, `ST_CFG_POL`, `ST_CFG_MODE`, `ST_REG_READ`, `ST_HALT`.

Transitions:
- `ST_IDLE` goes to `ST_RD_STREAM` on F5h.
- `ST_IDLE` goes to `ST_WR_DATA` on 5Ah.
- `ST_IDLE` goes to `ST_PULSE_MASK` on A5h.
- `ST_IDLE` goes to `ST_CFG_SEL` on 3Ch.
- `ST_IDLE` goes to `ST_REG_READ` on 69h.
- `ST_IDLE` goes to `ST_HALT` on C3h or on any other byte.
- `ST_WR_DATA` goes to `ST_WR_INV` on a byte.
- `ST_WR_INV` goes to `ST_WR_ACK` on a matching complement, or to `ST_HALT` on a mismatch.
- `ST_WR_ACK` goes to `ST_WR_SAMPLE` on a read.
- `ST_WR_SAMPLE` goes to `ST_WR_DATA` on a read.
- `ST_PULSE_MASK` goes to `ST_PULSE_RUN` on a non-empty mask, or to `ST_HALT` on an empty one.
- `ST_PULSE_RUN` goes to `ST_HALT` when the pulse ends.
- `ST_CFG_SEL` goes to `ST_CFG_POL`, then to `ST_CFG_MODE`, then to `ST_HALT`, one byte per step.
- Every state goes to `ST_IDLE` on `bus_rst`.

Top module: `pio_access_unit`

## Requirements
- R1: After `rst_n` goes low, the following hold: `tx_valid` is 0; `pin_drive_low` is all 0 because the output latch resets to all 1 (released); the activity latches, select mask, polarity mask and mode are 0; `cond_out` is 0.
- R2: Every `tx_req` produces exactly one `tx_valid` pulse in the next cycle. In the stream state the byte is the status byte. Its low nibble is the synchronised pin levels (pin i in bit i, zero-extended). Its high nibble is the bitwise complement of the low nibble.
- R3: In the stream, after every BLOCK_BYTES status bytes come two bytes: first the low byte of the complemented CRC-16, then its high byte. The CRC uses the reflected polynomial A001h, starts from 0, and covers only that block's status bytes. It restarts from 0 for the next block.
- R4: `bus_rst` ends any command and returns to idle, where reads give FFh. It releases a pulse in progress. It keeps the output latch, the activity latches and the configuration.
- R5: In the write command, a data byte followed by its exact bitwise complement loads data bits [NPIO-1:0] into the output latch. A 0 bit drives its pin low. The next read returns AAh.
- R6: The read after AAh returns the status byte (R2 format) of the synchronised pins as they were when AAh was delivered. The unit then accepts another data/complement pair.
- R7: A complement that does not match leaves the output latch unchanged. Every later read returns FFh until `bus_rst`.
- R8: An activity latch sets on any change of its synchronised pin and stays set. Only the clear command (C3h) or `rst_n` clears it. Register read byte 0 shows the latches in bits [NPIO-1:0].
- R9: `cond_out` works as follows:
  - A selected channel matches when its activity latch equals its polarity bit.
  - With mode bit 0 = 0 (OR), `cond_out` is 1 when any selected channel matches.
  - With mode bit 0 = 1 (AND), `cond_out` is 1 when every selected channel matches.
  - `cond_out` is 0 when no channel is selected.
  - The configure command takes three bytes in order: select, polarity, mode.
- R10: The pulse command takes a mask byte. A non-empty mask pulls the masked pins low for exactly PULSE_LEN cycles and then releases them, and unmasked pins are not touched. An empty mask gives no pulse.
- R11: An unknown command byte leads to a state in which all reads return FFh until `bus_rst`.
- R12: Register read returns four bytes: activity, select, polarity, mode (each zero-extended). After that every read returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Synchronous command abort (bus reset seen) |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte from master |
| tx_req | input | 1 | Master requests one response byte |
| tx_valid | output | 1 | Response byte valid, one cycle after `tx_req` |
| tx_byte | output | 8 | Response byte |
| pin_in | input | NPIO | Pin levels as seen at the pads |
| pin_drive_low | output | NPIO | Pull-down enable per pin |
| cond_out | output | 1 | Conditional search participation flag |

## Verification
The bench builds the unit with two pins and a 32-byte CRC block, so that the real block boundary and both CRC bytes are checked against an independent bitwise CRC model. PULSE_LEN is cut to 8, so the first and last low cycles of a pulse, and an abort in mid-pulse, can be checked cycle-exactly. The pins are modelled as open-drain with external pull-ups. Writes and pulses therefore loop back into the status samples and set the activity latches, which exercises every combine mode and polarity of the search flag.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STREAM,
        ST_WR_DATA,
        ST_WR_INV,
        ST_WR_ACK,
        ST_WR_SAMPLE,
        ST_PULSE_MASK,
        ST_PULSE_RUN,
        ST_CFG_SEL,
        ST_CFG_POL,
        ST_CFG_MODE,
        ST_REG_READ,
        ST_HALT
    } pio_state_e;

    localparam logic [7:0] CMD_STREAM  = 8'hF5;
    localparam logic [7:0] CMD_WRITE   = 8'h5A;
    localparam logic [7:0] CMD_PULSE   = 8'hA5;
    localparam logic [7:0] CMD_CLR_ACT = 8'hC3;
    localparam logic [7:0] CMD_CONFIG  = 8'h3C;
    localparam logic [7:0] CMD_REGRD   = 8'h69;

    localparam logic [7:0] RSP_ACK  = 8'hAA;
    localparam logic [7:0] RSP_IDLE = 8'hFF;

endpackage

// File: rtl/pio_crc16.sv
module pio_crc16 #(
    parameter logic [15:0] POLY_REFL = 16'hA001
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] c;
        c = crc_in ^ {8'h00, data_in};
        for (int b = 0; b < 8; b++) begin
            if (c[0]) c = (c >> 1) ^ POLY_REFL;
            else      c = c >> 1;
        end
        crc_out = c;
    end
endmodule

// File: rtl/pio_sense.sv
module pio_sense #(
    parameter int NPIO = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIO-1:0] pin_in,
    input  logic            act_clr,
    input  logic [NPIO-1:0] sel,
    input  logic [NPIO-1:0] pol,
    input  logic            mode_and,
    output logic [NPIO-1:0] pin_s,
    output logic [NPIO-1:0] act,
    output logic            cond
);
    logic [NPIO-1:0] sync1_q, sync2_q, prev_q, act_q;
    logic [NPIO-1:0] match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '1;
            sync2_q <= '1;
            prev_q  <= '1;
            act_q   <= '0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
            if (act_clr) act_q <= '0;
            else         act_q <= act_q | (sync2_q ^ prev_q);
        end
    end

    assign match = sel & ~(act_q ^ pol);

    always_comb begin
        if (sel == '0)     cond = 1'b0;
        else if (mode_and) cond = ((match | ~sel) == '1);
        else               cond = |match;
    end

    assign pin_s = sync2_q;
    assign act   = act_q;

    AST_ACT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !act_clr |=> ((act_q & $past(act_q)) == $past(act_q))); // R8
    AST_COND_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> !cond); // R9
endmodule

// File: rtl/pio_pulse.sv
module pio_pulse #(
    parameter int NPIO      = 2,
    parameter int PULSE_LEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic [NPIO-1:0] mask_in,
    output logic            active,
    output logic [NPIO-1:0] mask
);
    localparam int TW = $clog2(PULSE_LEN + 1);
    localparam logic [TW-1:0] LEN_C = TW'(PULSE_LEN);

    logic [TW-1:0]   cnt_q;
    logic [NPIO-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mask_q <= '0;
        end else if (abort) begin
            cnt_q  <= '0;
        end else if (start) begin
            cnt_q  <= LEN_C;
            mask_q <= mask_in;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);
    assign mask   = active ? mask_q : '0;

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> active); // R10
    AST_PULSE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !active); // R4
endmodule

// File: rtl/pio_access_unit.sv
module pio_access_unit
    import pio_pkg::*;
#(
    parameter int NPIO        = 2,
    parameter int BLOCK_BYTES = 32,
    parameter int PULSE_LEN   = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_rst,
    input  logic            rx_valid,
    input  logic [7:0]      rx_byte,
    input  logic            tx_req,
    output logic            tx_valid,
    output logic [7:0]      tx_byte,
    input  logic [NPIO-1:0] pin_in,
    output logic [NPIO-1:0] pin_drive_low,
    output logic            cond_out
);
    localparam int CW = $clog2(BLOCK_BYTES + 2);
    localparam logic [CW-1:0] BLK_C    = CW'(BLOCK_BYTES);
    localparam logic [CW-1:0] REG_LAST = CW'(4);

    pio_state_e state_q, state_d;

    logic [NPIO-1:0] olat_q, sel_q, pol_q;
    logic            mode_q;
    logic [7:0]      data_q, samp_q;
    logic [15:0]     crc_q, crc_nx;
    logic [CW-1:0]   bcnt_q;
    logic [NPIO-1:0] pin_s, act;
    logic            pulse_on;
    logic [NPIO-1:0] pulse_mask;
    logic [7:0]      status, resp;
    logic [3:0]      lo;
    logic            pair_ok, pulse_start, act_clr;

    // status byte: synced pins in low nibble, complement in high nibble
    always_comb begin
        lo = '0;
        lo[NPIO-1:0] = pin_s;
        status = {~lo, lo};
    end

    assign pair_ok     = (rx_byte == ~data_q);
    assign pulse_start = (state_q == ST_PULSE_MASK) && rx_valid && !bus_rst
                         && (rx_byte[NPIO-1:0] != '0);
    assign act_clr     = (state_q == ST_IDLE) && rx_valid && !bus_rst
                         && (rx_byte == CMD_CLR_ACT);

    pio_crc16 u_crc (
        .crc_in  (crc_q),
        .data_in (status),
        .crc_out (crc_nx)
    );

    pio_sense #(.NPIO(NPIO)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .act_clr  (act_clr),
        .sel      (sel_q),
        .pol      (pol_q),
        .mode_and (mode_q),
        .pin_s    (pin_s),
        .act      (act),
        .cond     (cond_out)
    );

    pio_pulse #(.NPIO(NPIO), .PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (pulse_start),
        .abort   (bus_rst),
        .mask_in (rx_byte[NPIO-1:0]),
        .active  (pulse_on),
        .mask    (pulse_mask)
    );

    assign pin_drive_low = ~olat_q | pulse_mask;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (bus_rst) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (rx_valid) begin
                    unique case (rx_byte)
                        CMD_STREAM: state_d = ST_RD_STREAM;
                        CMD_WRITE:  state_d = ST_WR_DATA;
                        CMD_PULSE:  state_d = ST_PULSE_MASK;
                        CMD_CONFIG: state_d = ST_CFG_SEL;
                        CMD_REGRD:  state_d = ST_REG_READ;
                        default:    state_d = ST_HALT;
                    endcase
                end
                ST_RD_STREAM:  state_d = ST_RD_STREAM;
                ST_WR_DATA:    if (rx_valid) state_d = ST_WR_INV;
                ST_WR_INV:     if (rx_valid) state_d = pair_ok ? ST_WR_ACK : ST_HALT;
                ST_WR_ACK:     if (tx_req) state_d = ST_WR_SAMPLE;
                ST_WR_SAMPLE:  if (tx_req) state_d = ST_WR_DATA;
                ST_PULSE_MASK: if (rx_valid)
                                   state_d = (rx_byte[NPIO-1:0] != '0) ? ST_PULSE_RUN : ST_HALT;
                ST_PULSE_RUN:  if (!pulse_on) state_d = ST_HALT;
                ST_CFG_SEL:    if (rx_valid) state_d = ST_CFG_POL;
                ST_CFG_POL:    if (rx_valid) state_d = ST_CFG_MODE;
                ST_CFG_MODE:   if (rx_valid) state_d = ST_HALT;
                ST_REG_READ:   state_d = ST_REG_READ;
                ST_HALT:       state_d = ST_HALT;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // response byte selection
    always_comb begin
        resp = RSP_IDLE;
        unique case (state_q)
            ST_RD_STREAM: begin
                if (bcnt_q < BLK_C)       resp = status;
                else if (bcnt_q == BLK_C) resp = ~crc_q[7:0];
                else                      resp = ~crc_q[15:8];
            end
            ST_WR_ACK:    resp = RSP_ACK;
            ST_WR_SAMPLE: resp = samp_q;
            ST_REG_READ: begin
                unique case (bcnt_q)
                    CW'(0):  begin resp = '0; resp[NPIO-1:0] = act;   end
                    CW'(1):  begin resp = '0; resp[NPIO-1:0] = sel_q; end
                    CW'(2):  begin resp = '0; resp[NPIO-1:0] = pol_q; end
                    CW'(3):  resp = {7'b0, mode_q};
                    default: resp = RSP_IDLE;
                endcase
            end
            default: resp = RSP_IDLE;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= RSP_IDLE;
            olat_q   <= '1;
            sel_q    <= '0;
            pol_q    <= '0;
            mode_q   <= 1'b0;
            data_q   <= '0;
            samp_q   <= '0;
            crc_q    <= '0;
            bcnt_q   <= '0;
        end else begin
            tx_valid <= tx_req;
            if (tx_req) tx_byte <= resp;
            if (bus_rst) begin
                bcnt_q <= '0;
                crc_q  <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        bcnt_q <= '0;
                        crc_q  <= '0;
                    end
                    ST_RD_STREAM: if (tx_req) begin
                        if (bcnt_q < BLK_C) begin
                            crc_q  <= crc_nx;
                            bcnt_q <= bcnt_q + 1'b1;
                        end else if (bcnt_q == BLK_C) begin
                            bcnt_q <= bcnt_q + 1'b1;
                        end else begin
                            crc_q  <= '0;
                            bcnt_q <= '0;
                        end
                    end
                    ST_WR_DATA:  if (rx_valid) data_q <= rx_byte;
                    ST_WR_INV:   if (rx_valid && pair_ok) olat_q <= data_q[NPIO-1:0];
                    ST_WR_ACK:   if (tx_req) samp_q <= status;
                    ST_CFG_SEL:  if (rx_valid) sel_q  <= rx_byte[NPIO-1:0];
                    ST_CFG_POL:  if (rx_valid) pol_q  <= rx_byte[NPIO-1:0];
                    ST_CFG_MODE: if (rx_valid) mode_q <= rx_byte[0];
                    ST_REG_READ: if (tx_req && bcnt_q != REG_LAST) bcnt_q <= bcnt_q + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    AST_TX_PER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid); // R2
    AST_NO_SPURIOUS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !tx_valid); // R2
    AST_STREAM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_STREAM) |-> (bcnt_q <= BLK_C + 1'b1)); // R3
    AST_BAD_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_INV && rx_valid && !bus_rst && !pair_ok) |=> $stable(pin_drive_low)); // R7
    AST_RST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (pin_drive_low == ~olat_q)); // R4
    AST_ACK_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_ACK && tx_req) |=> (tx_byte == RSP_ACK)); // R5
endmodule

// File: tb/pio_access_unit_tb_top.sv
module pio_access_unit_tb_top;
    localparam int NP  = 2;
    localparam int BLK = 32;
    localparam int PL  = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, bus_rst, rx_valid, tx_req, tx_valid, cond_out;
    logic [7:0]    rx_byte, tx_byte;
    logic [NP-1:0] pin_in, pin_drive_low, ext;

    assign pin_in = ext & ~pin_drive_low;

    pio_access_unit #(.NPIO(NP), .BLOCK_BYTES(BLK), .PULSE_LEN(PL)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .pin_in(pin_in), .pin_drive_low(pin_drive_low), .cond_out(cond_out)
    );

    int vectors = 0, miscompares = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         done = 1'b0;

    // monitor: pops expected bytes as responses appear
    always @(negedge clk) begin
        if (tx_valid) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL unexpected byte act=%h exp=none", tx_byte);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (tx_byte !== e) begin
                    miscompares++;
                    $display("FAIL %s act=%h exp=%h", t, tx_byte, e);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [7:0] a, input logic [7:0] e);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", tag, a, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic brst();
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    function automatic logic [7:0] stat(input logic [NP-1:0] p);
        logic [3:0] l;
        l = '0;
        l[NP-1:0] = p;
        return {~l, l};
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        return r;
    endfunction

    task automatic cfg_chk(input logic [7:0] s, input logic [7:0] p, input logic [7:0] m,
                           input logic e, input string tag);
        send(8'h3C); send(s); send(p); send(m);
        brst();
        chk(cond_out === e, tag, {7'b0, cond_out}, {7'b0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] crc;
        rst_n = 1'b0; bus_rst = 1'b0; rx_valid = 1'b0; rx_byte = '0; tx_req = 1'b0;
        ext = '1;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk(pin_drive_low === '0, "R1 drive", {6'b0, pin_drive_low}, 8'h00);
        chk(tx_valid === 1'b0, "R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        chk(cond_out === 1'b0, "R1 cond", {7'b0, cond_out}, 8'h00);
        send(8'h69);
        rd(8'h00, "R1 act"); rd(8'h00, "R1 sel"); rd(8'h00, "R1 pol"); rd(8'h00, "R1 mode");
        brst();

        // R2 / R3 stream with CRC blocks
        send(8'hF5);
        crc = '0;
        for (int i = 0; i < BLK; i++) begin
            if (i == 10) begin ext = 2'b01; idle(4); end
            rd(stat(ext), "R2 status");
            crc = crc_step(crc, stat(ext));
        end
        rd(~crc[7:0], "R3 crc lo");
        rd(~crc[15:8], "R3 crc hi");
        crc = '0;
        for (int i = 0; i < BLK; i++) begin
            rd(stat(ext), "R2 status blk2");
            crc = crc_step(crc, stat(ext));
        end
        rd(~crc[7:0], "R3 crc lo blk2");
        rd(~crc[15:8], "R3 crc hi blk2");
        rd(stat(ext), "R3 restart");
        brst();
        rd(8'hFF, "R4 idle read");
        ext = 2'b11;
        idle(4);

        // R5 / R6 write with ack and sample
        send(8'h5A); send(8'h02); send(8'hFD);
        chk(pin_drive_low === 2'b01, "R5 drive", {6'b0, pin_drive_low}, 8'h01);
        idle(4);
        rd(8'hAA, "R5 ack");
        rd(stat(2'b10), "R6 sample");
        send(8'h03); send(8'hFC);
        idle(4);
        rd(8'hAA, "R5 ack2");
        rd(stat(2'b11), "R6 sample2");

        // R7 bad complement
        send(8'h00); send(8'h00);
        rd(8'hFF, "R7 bad pair");
        chk(pin_drive_low === 2'b00, "R7 pins held", {6'b0, pin_drive_low}, 8'h00);
        rd(8'hFF, "R7 halt");
        brst();

        // R8 activity latches
        send(8'hC3); brst();
        send(8'h69);
        rd(8'h00, "R8 cleared"); rd(8'h00, "R12 sel"); rd(8'h00, "R12 pol");
        rd(8'h00, "R12 mode"); rd(8'hFF, "R12 tail");
        brst();
        ext = 2'b10; idle(4); ext = 2'b11; idle(4);
        brst();
        send(8'h69); rd(8'h01, "R8 set sticky"); brst();

        // R9 condition flag (act = 01)
        cfg_chk(8'h03, 8'h01, 8'h00, 1'b1, "R9 or match");
        cfg_chk(8'h03, 8'h01, 8'h01, 1'b1, "R9 and match");
        cfg_chk(8'h03, 8'h02, 8'h00, 1'b0, "R9 or none");
        cfg_chk(8'h03, 8'h03, 8'h00, 1'b1, "R9 or one");
        cfg_chk(8'h03, 8'h03, 8'h01, 1'b0, "R9 and partial");
        cfg_chk(8'h02, 8'h00, 8'h01, 1'b1, "R9 and subset");
        cfg_chk(8'h00, 8'h00, 8'h00, 1'b0, "R9 no select");
        cfg_chk(8'h02, 8'h00, 8'h01, 1'b1, "R9 restore");

        // R12 register read
        send(8'h69);
        rd(8'h01, "R12 act"); rd(8'h02, "R12 sel2"); rd(8'h00, "R12 pol2");
        rd(8'h01, "R12 mode2"); rd(8'hFF, "R12 end"); rd(8'hFF, "R12 end2");
        brst();

        // R10 pulse
        send(8'hA5); send(8'h01);
        chk(pin_drive_low === 2'b01, "R10 pulse first", {6'b0, pin_drive_low}, 8'h01);
        idle(PL - 1);
        chk(pin_drive_low === 2'b01, "R10 pulse last", {6'b0, pin_drive_low}, 8'h01);
        idle(1);
        chk(pin_drive_low === 2'b00, "R10 pulse end", {6'b0, pin_drive_low}, 8'h00);
        brst();
        send(8'hA5); send(8'h00);
        chk(pin_drive_low === 2'b00, "R10 empty mask", {6'b0, pin_drive_low}, 8'h00);
        rd(8'hFF, "R10 empty halt");
        brst();

        // R4 abort pulse
        send(8'hA5); send(8'h02);
        idle(2);
        chk(pin_drive_low === 2'b10, "R4 pulse on", {6'b0, pin_drive_low}, 8'h02);
        brst();
        chk(pin_drive_low === 2'b00, "R4 pulse abort", {6'b0, pin_drive_low}, 8'h00);

        // R11 unknown command
        send(8'h11);
        rd(8'hFF, "R11 unknown");
        rd(8'hFF, "R11 unknown2");
        brst();

        idle(4);
        chk(exp_q.size() == 0, "queue drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule